// File: doc/BRIEF.md
# Mailbox and Run-Control Register Interface

This block is the host-facing register file of an accelerator core. The host reaches it through a single-cycle request port with a word offset. Through it the host passes 32-bit messages to the core via a four-deep inbound mailbox. It collects messages from the core via an outbound mailbox and an outbound interrupt mailbox. It reads one packed word that reports the occupancy of all three mailboxes.

The same register file starts and stops the core. A run-control register accepts run and stop commands, a running flag reports the state, and a next-program-counter register holds the entry point the core starts from. Values that cannot be legal are dropped before they reach the core. Two signal-notification registers turn each host write into a one-cycle notification event toward the core.

On the core side, the inbound mailbox is drained with a pop strobe. Both outbound mailboxes are filled with push strobes. Register reads return data one cycle after the request.

Top module: `mbox_runctl_regs`

## Requirements
- R1: Each host write to word offset 0 pushes one entry into the inbound mailbox, which holds 4 entries. The core pops them with `core_in_pop` in write order, and `core_in_valid` is low when the mailbox is empty.
- R2: A host write to offset 0 while the inbound mailbox is full is dropped and sets `in_overflow`. The flag stays set until reset.
- R3: A read of offset 3 returns the mailbox status word. Bits [7:0] hold the outbound mailbox count. Bits [15:8] hold the inbound free slots, which is 4 minus the occupancy. Bits [23:16] hold the outbound interrupt mailbox count. Bits [31:24] read zero.
- R4: A read of offset 1 pops and returns the head of the outbound mailbox. When that mailbox is empty the read returns zero and the count stays zero.
- R5: A read of offset 2 pops and returns the head of the outbound interrupt mailbox, with the same empty behaviour as R4.
- R6: Writing 1 to run-control (offset 4) sets the running flag, which reads as bit 0 of offset 5. If the core was idle, `core_start` pulses high for exactly one cycle. A run command while already running gives no pulse.
- R7: Writing 2 to run-control clears the running flag and pulses `core_stop` for one cycle.
- R8: Any other value written to run-control changes nothing. A read of offset 4 returns the last accepted command, or zero after reset.
- R9: A write to the next-program-counter register (offset 6) is dropped when bit 1 is set or the value is 0x40000 or more. Reads return the last accepted value.
- R10: A write to offset 7 or offset 8 pulses bit 0 or bit 1 of `sig_evt` respectively for one cycle. The written word appears on `sig_data` in the same cycle.
- R11: A read or write of an unmapped offset, or an access in the wrong direction, makes `host_err` high for one cycle with the response. A read of that kind returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word offset of the register |
| host_wdata | input | DATA_W | Write data |
| host_rvalid | output | 1 | Read response valid, one cycle after the request |
| host_rdata | output | DATA_W | Read response data |
| host_err | output | 1 | Illegal access, in the response cycle |
| core_in_pop | input | 1 | Core removes the inbound head |
| core_in_data | output | DATA_W | Inbound mailbox head |
| core_in_valid | output | 1 | Inbound mailbox not empty |
| core_out_push | input | 1 | Core pushes an outbound message |
| core_out_data | input | DATA_W | Outbound message |
| core_out_full | output | 1 | Outbound mailbox full |
| core_intr_push | input | 1 | Core pushes an interrupt message |
| core_intr_data | input | DATA_W | Interrupt message |
| core_intr_full | output | 1 | Interrupt mailbox full |
| core_start | output | 1 | One-cycle start pulse |
| core_stop | output | 1 | One-cycle stop pulse |
| core_running | output | 1 | Running flag |
| core_npc | output | DATA_W | Next program counter |
| sig_evt | output | 2 | Notification pulses, one per signal register |
| sig_data | output | DATA_W | Notification payload |
| in_overflow | output | 1 | Sticky inbound overflow flag |

## Verification
The bench fills the inbound mailbox and then writes once more. A design that let this fifth write through would overwrite the oldest entry, and the pop order would show it. The bench reads empty outbound mailboxes; a pointer underflow would return stale data or make the status count wrap to 255. It also writes run-control values that are neither run nor stop, a second run while already running, and program-counter values just inside and just outside the legal range. A design that stored a bad command, pulsed start twice, or got the bound off by one would show up in the read-back or on the pulse outputs. Unmapped offsets and accesses in the wrong direction must give exactly one error pulse with zero data.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // register word offsets
    localparam int OFF_INBOX   = 0;
    localparam int OFF_OUTBOX  = 1;
    localparam int OFF_INTRBOX = 2;
    localparam int OFF_MBSTAT  = 3;
    localparam int OFF_RUNCTL  = 4;
    localparam int OFF_RUNSTAT = 5;
    localparam int OFF_NPC     = 6;
    localparam int OFF_SIG0    = 7;
    localparam int OFF_SIG1    = 8;

    localparam logic [31:0] RUN_REQ   = 32'd1;
    localparam logic [31:0] STOP_REQ  = 32'd2;
    localparam logic [31:0] NPC_LIMIT = 32'h0004_0000;

    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_RUN  = 2'd1,
        RC_STOP = 2'd2
    } run_cmd_e;

    typedef struct packed {
        logic [7:0] zero;
        logic [7:0] intr_cnt;
        logic [7:0] in_free;
        logic [7:0] out_cnt;
    } mbstat_t;

    function automatic run_cmd_e decode_run(input logic [31:0] v);
        if (v == RUN_REQ)       return RC_RUN;
        else if (v == STOP_REQ) return RC_STOP;
        else                    return RC_NONE;
    endfunction

    function automatic logic npc_legal(input logic [31:0] v);
        return (v[1] == 1'b0) && (v < NPC_LIMIT);
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)) else $error("count above depth"); // R1
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count))) else $error("push on full stored"); // R2
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty) else $error("pop on empty underflowed"); // R4

endmodule

// File: rtl/mbox_runctl.sv
module mbox_runctl
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_run,
    input  logic              wr_npc,
    input  logic [DATA_W-1:0] wdata,
    output logic              running,
    output logic              start,
    output logic              stop,
    output logic [DATA_W-1:0] run_val,
    output logic [DATA_W-1:0] npc
);

    run_cmd_e cmd;
    assign cmd = decode_run(32'(wdata));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            start   <= 1'b0;
            stop    <= 1'b0;
            run_val <= '0;
            npc     <= '0;
        end else begin
            start <= 1'b0;
            stop  <= 1'b0;
            if (wr_run) begin
                case (cmd)
                    RC_RUN: begin
                        run_val <= wdata;
                        if (!running) begin
                            running <= 1'b1;
                            start   <= 1'b1;
                        end
                    end
                    RC_STOP: begin
                        run_val <= wdata;
                        running <= 1'b0;
                        stop    <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (wr_npc && npc_legal(32'(wdata))) npc <= wdata;
        end
    end

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (running && !$past(running))) else $error("start while running"); // R6
    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        stop |-> !running) else $error("stop left core running"); // R7
    AST_RUNVAL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (run_val == '0) || (run_val == DATA_W'(RUN_REQ)) || (run_val == DATA_W'(STOP_REQ)))
        else $error("illegal run-control stored"); // R8
    AST_NPC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (npc[1] == 1'b0) && (32'(npc) < NPC_LIMIT)) else $error("illegal npc stored"); // R9

endmodule

// File: rtl/mbox_runctl_regs.sv
module mbox_runctl_regs
    import mbox_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int IN_DEPTH   = 4,
    parameter int OUT_DEPTH  = 1,
    parameter int INTR_DEPTH = 1,
    parameter int NUM_SIG    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic               host_rvalid,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_err,
    input  logic               core_in_pop,
    output logic [DATA_W-1:0]  core_in_data,
    output logic               core_in_valid,
    input  logic               core_out_push,
    input  logic [DATA_W-1:0]  core_out_data,
    output logic               core_out_full,
    input  logic               core_intr_push,
    input  logic [DATA_W-1:0]  core_intr_data,
    output logic               core_intr_full,
    output logic               core_start,
    output logic               core_stop,
    output logic               core_running,
    output logic [DATA_W-1:0]  core_npc,
    output logic [NUM_SIG-1:0] sig_evt,
    output logic [DATA_W-1:0]  sig_data,
    output logic               in_overflow
);

    localparam int IN_CW   = $clog2(IN_DEPTH + 1);
    localparam int OUT_CW  = $clog2(OUT_DEPTH + 1);
    localparam int INTR_CW = $clog2(INTR_DEPTH + 1);

    localparam logic [ADDR_W-1:0] A_INBOX   = ADDR_W'(OFF_INBOX);
    localparam logic [ADDR_W-1:0] A_OUTBOX  = ADDR_W'(OFF_OUTBOX);
    localparam logic [ADDR_W-1:0] A_INTRBOX = ADDR_W'(OFF_INTRBOX);
    localparam logic [ADDR_W-1:0] A_MBSTAT  = ADDR_W'(OFF_MBSTAT);
    localparam logic [ADDR_W-1:0] A_RUNCTL  = ADDR_W'(OFF_RUNCTL);
    localparam logic [ADDR_W-1:0] A_RUNSTAT = ADDR_W'(OFF_RUNSTAT);
    localparam logic [ADDR_W-1:0] A_NPC     = ADDR_W'(OFF_NPC);
    localparam logic [ADDR_W-1:0] A_SIG0    = ADDR_W'(OFF_SIG0);

    // mailboxes
    logic [IN_CW-1:0]   in_cnt;
    logic [OUT_CW-1:0]  out_cnt;
    logic [INTR_CW-1:0] intr_cnt;
    logic               in_full, in_empty, out_empty, intr_empty;
    logic [DATA_W-1:0]  out_head, intr_head;

    // decode
    logic               rd, wr, legal;
    logic               wr_in, wr_run, wr_npc, pop_out, pop_intr;
    logic [NUM_SIG-1:0] wr_sig;
    logic [DATA_W-1:0]  rd_val, run_val;
    mbstat_t            stat;

    assign rd = host_req && !host_wr;
    assign wr = host_req && host_wr;

    mbox_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in (
        .clk(clk), .rst(rst), .push(wr_in), .wdata(host_wdata), .pop(core_in_pop),
        .rdata(core_in_data), .count(in_cnt), .full(in_full), .empty(in_empty)
    );

    mbox_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out (
        .clk(clk), .rst(rst), .push(core_out_push), .wdata(core_out_data), .pop(pop_out),
        .rdata(out_head), .count(out_cnt), .full(core_out_full), .empty(out_empty)
    );

    mbox_fifo #(.W(DATA_W), .DEPTH(INTR_DEPTH)) u_intr (
        .clk(clk), .rst(rst), .push(core_intr_push), .wdata(core_intr_data), .pop(pop_intr),
        .rdata(intr_head), .count(intr_cnt), .full(core_intr_full), .empty(intr_empty)
    );

    assign core_in_valid = !in_empty;

    always_comb begin
        stat          = '0;
        stat.out_cnt  = 8'(out_cnt);
        stat.in_free  = 8'(IN_DEPTH) - 8'(in_cnt);
        stat.intr_cnt = 8'(intr_cnt);
    end

    mbox_runctl #(.DATA_W(DATA_W)) u_run (
        .clk(clk), .rst(rst), .wr_run(wr_run), .wr_npc(wr_npc), .wdata(host_wdata),
        .running(core_running), .start(core_start), .stop(core_stop),
        .run_val(run_val), .npc(core_npc)
    );

    always_comb begin
        legal    = 1'b0;
        rd_val   = '0;
        wr_in    = 1'b0;
        wr_run   = 1'b0;
        wr_npc   = 1'b0;
        wr_sig   = '0;
        pop_out  = 1'b0;
        pop_intr = 1'b0;
        if (rd) begin
            case (host_addr)
                A_OUTBOX: begin
                    legal   = 1'b1;
                    pop_out = 1'b1;
                    rd_val  = out_empty ? '0 : out_head;
                end
                A_INTRBOX: begin
                    legal    = 1'b1;
                    pop_intr = 1'b1;
                    rd_val   = intr_empty ? '0 : intr_head;
                end
                A_MBSTAT: begin
                    legal  = 1'b1;
                    rd_val = DATA_W'(stat);
                end
                A_RUNCTL: begin
                    legal  = 1'b1;
                    rd_val = run_val;
                end
                A_RUNSTAT: begin
                    legal  = 1'b1;
                    rd_val = DATA_W'(core_running);
                end
                A_NPC: begin
                    legal  = 1'b1;
                    rd_val = core_npc;
                end
                default: ;
            endcase
        end
        if (wr) begin
            case (host_addr)
                A_INBOX:  begin legal = 1'b1; wr_in  = 1'b1; end
                A_RUNCTL: begin legal = 1'b1; wr_run = 1'b1; end
                A_NPC:    begin legal = 1'b1; wr_npc = 1'b1; end
                default: begin
                    for (int s = 0; s < NUM_SIG; s++) begin
                        if (host_addr == A_SIG0 + ADDR_W'(s)) begin
                            legal     = 1'b1;
                            wr_sig[s] = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // response and overflow
    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
            host_err    <= 1'b0;
            in_overflow <= 1'b0;
            sig_data    <= '0;
        end else begin
            host_rvalid <= rd;
            host_rdata  <= rd ? rd_val : '0;
            host_err    <= host_req && !legal;
            if (wr_in && in_full) in_overflow <= 1'b1;
            if (|wr_sig) sig_data <= host_wdata;
        end
    end

    // one pulse register per signal-notification register
    for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
        always_ff @(posedge clk) begin
            if (rst) sig_evt[g] <= 1'b0;
            else     sig_evt[g] <= wr_sig[g];
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(in_overflow) |-> in_overflow) else $error("overflow flag cleared"); // R2
    AST_SIG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sig_evt)) else $error("two notifications at once"); // R10
    AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        host_err |-> $past(host_req)) else $error("error without access"); // R11
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        host_err |-> (host_rdata == '0)) else $error("error with data"); // R11

endmodule

// File: tb/mbox_runctl_regs_bench.sv
`timescale 1ns/1ps
module mbox_runctl_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_rvalid, host_err;
    logic [31:0] host_rdata;
    logic        core_in_pop = 1'b0;
    logic [31:0] core_in_data;
    logic        core_in_valid;
    logic        core_out_push = 1'b0, core_intr_push = 1'b0;
    logic [31:0] core_out_data = '0, core_intr_data = '0;
    logic        core_out_full, core_intr_full;
    logic        core_start, core_stop, core_running;
    logic [31:0] core_npc;
    logic [1:0]  sig_evt;
    logic [31:0] sig_data;
    logic        in_overflow;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mbox_runctl_regs u_mbox_runctl_regs (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .host_err(host_err), .core_in_pop(core_in_pop),
        .core_in_data(core_in_data), .core_in_valid(core_in_valid),
        .core_out_push(core_out_push), .core_out_data(core_out_data),
        .core_out_full(core_out_full), .core_intr_push(core_intr_push),
        .core_intr_data(core_intr_data), .core_intr_full(core_intr_full),
        .core_start(core_start), .core_stop(core_stop), .core_running(core_running),
        .core_npc(core_npc), .sig_evt(sig_evt), .sig_data(sig_data),
        .in_overflow(in_overflow)
    );

    localparam logic [3:0] INBOX = 4'd0, OUTBOX = 4'd1, INTRBOX = 4'd2, MBSTAT = 4'd3,
                           RUNCTL = 4'd4, RUNSTAT = 4'd5, NPC = 4'd6, SIG0 = 4'd7,
                           SIG1 = 4'd8, UNMAPPED = 4'd15;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } tv_t;

    localparam int NV = 24;
    localparam tv_t TV [NV] = '{
        '{1'b0, MBSTAT,  32'h0,       32'h0000_0400, 8'd3},  // R3 after reset
        '{1'b1, INBOX,   32'h11,      32'h0,         8'd1},  // R1
        '{1'b0, MBSTAT,  32'h0,       32'h0000_0300, 8'd3},  // R3 one slot used
        '{1'b1, RUNCTL,  32'h5,       32'h0,         8'd8},  // R8 bad value
        '{1'b0, RUNCTL,  32'h0,       32'h0,         8'd8},
        '{1'b1, RUNCTL,  32'h1,       32'h0,         8'd6},  // R6
        '{1'b0, RUNCTL,  32'h0,       32'h1,         8'd8},
        '{1'b0, RUNSTAT, 32'h0,       32'h1,         8'd6},
        '{1'b1, RUNCTL,  32'h3,       32'h0,         8'd8},
        '{1'b0, RUNCTL,  32'h0,       32'h1,         8'd8},
        '{1'b1, NPC,     32'h100,     32'h0,         8'd9},  // R9
        '{1'b0, NPC,     32'h0,       32'h100,       8'd9},
        '{1'b1, NPC,     32'h102,     32'h0,         8'd9},  // bit 1 set
        '{1'b0, NPC,     32'h0,       32'h100,       8'd9},
        '{1'b1, NPC,     32'h4_0000,  32'h0,         8'd9},  // at limit
        '{1'b0, NPC,     32'h0,       32'h100,       8'd9},
        '{1'b1, NPC,     32'h3_FFFC,  32'h0,         8'd9},  // just inside
        '{1'b0, NPC,     32'h0,       32'h3_FFFC,    8'd9},
        '{1'b0, OUTBOX,  32'h0,       32'h0,         8'd4},  // R4 empty
        '{1'b0, INTRBOX, 32'h0,       32'h0,         8'd5},  // R5 empty
        '{1'b0, MBSTAT,  32'h0,       32'h0000_0300, 8'd3},
        '{1'b1, RUNCTL,  32'h2,       32'h0,         8'd7},  // R7
        '{1'b0, RUNSTAT, 32'h0,       32'h0,         8'd7},
        '{1'b0, RUNCTL,  32'h0,       32'h2,         8'd8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access; returns at the negedge where the response is visible
    task automatic access(input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = w; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_wr = 1'b0;
    endtask

    task automatic core_pop_check(input logic [31:0] exp);
        @(negedge clk);
        chk("R1 inbound valid", 32'(core_in_valid), 32'h1);
        chk("R1 inbound order", core_in_data, exp);
        core_in_pop = 1'b1;
        @(negedge clk);
        core_in_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("reset rvalid",  32'(host_rvalid), 32'h0);
        chk("reset running", 32'(core_running), 32'h0);
        chk("R1 reset inbound empty", 32'(core_in_valid), 32'h0);
        chk("R2 reset overflow", 32'(in_overflow), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            access(TV[i].wr, TV[i].addr, TV[i].data);
            if (TV[i].wr) begin
                chk($sformatf("R%0d vec %0d err", TV[i].req, i), 32'(host_err), 32'h0);
            end else begin
                chk($sformatf("R%0d vec %0d rvalid", TV[i].req, i), 32'(host_rvalid), 32'h1);
                chk($sformatf("R%0d vec %0d data", TV[i].req, i), host_rdata, TV[i].exp);
            end
        end

        // R1 / R2: fill, overflow, drain in order
        access(1'b1, INBOX, 32'h22);
        access(1'b1, INBOX, 32'h33);
        access(1'b1, INBOX, 32'h44);
        chk("R2 no overflow when filling", 32'(in_overflow), 32'h0);
        access(1'b0, MBSTAT, 32'h0);
        chk("R3 inbound full free=0", host_rdata, 32'h0);
        access(1'b1, INBOX, 32'h55);
        chk("R2 overflow set", 32'(in_overflow), 32'h1);
        core_pop_check(32'h11);
        core_pop_check(32'h22);
        core_pop_check(32'h33);
        core_pop_check(32'h44);
        chk("R1 drained", 32'(core_in_valid), 32'h0);
        chk("R2 overflow sticky", 32'(in_overflow), 32'h1);

        // R4: outbound mailbox, push on full dropped
        @(negedge clk); core_out_push = 1'b1; core_out_data = 32'hAB;
        @(negedge clk); core_out_data = 32'hCD;
        @(negedge clk); core_out_push = 1'b0;
        chk("R4 outbound full", 32'(core_out_full), 32'h1);
        access(1'b0, MBSTAT, 32'h0);
        chk("R3 outbound count", host_rdata, 32'h0000_0401);
        access(1'b0, OUTBOX, 32'h0);
        chk("R4 outbound head", host_rdata, 32'hAB);
        access(1'b0, OUTBOX, 32'h0);
        chk("R4 empty read zero", host_rdata, 32'h0);
        access(1'b0, MBSTAT, 32'h0);
        chk("R4 no underflow", host_rdata, 32'h0000_0400);

        // R5: interrupt mailbox
        @(negedge clk); core_intr_push = 1'b1; core_intr_data = 32'h77;
        @(negedge clk); core_intr_push = 1'b0;
        access(1'b0, MBSTAT, 32'h0);
        chk("R3 intr count", host_rdata, 32'h0001_0400);
        access(1'b0, INTRBOX, 32'h0);
        chk("R5 intr head", host_rdata, 32'h77);
        access(1'b0, INTRBOX, 32'h0);
        chk("R5 intr empty zero", host_rdata, 32'h0);

        // R6 / R7: pulses
        access(1'b1, RUNCTL, 32'h1);
        chk("R6 start pulse", 32'(core_start), 32'h1);
        chk("R6 running", 32'(core_running), 32'h1);
        @(negedge clk);
        chk("R6 start one cycle", 32'(core_start), 32'h0);
        access(1'b1, RUNCTL, 32'h1);
        chk("R6 no start when running", 32'(core_start), 32'h0);
        access(1'b1, RUNCTL, 32'h2);
        chk("R7 stop pulse", 32'(core_stop), 32'h1);
        chk("R7 running cleared", 32'(core_running), 32'h0);
        @(negedge clk);
        chk("R7 stop one cycle", 32'(core_stop), 32'h0);

        // R10: notifications
        access(1'b1, SIG1, 32'hDEAD);
        chk("R10 sig1 event", 32'(sig_evt), 32'h2);
        chk("R10 sig1 data", sig_data, 32'hDEAD);
        access(1'b1, SIG0, 32'hBEEF);
        chk("R10 sig0 event", 32'(sig_evt), 32'h1);
        chk("R10 sig0 data", sig_data, 32'hBEEF);
        @(negedge clk);
        chk("R10 event one cycle", 32'(sig_evt), 32'h0);

        // R11: illegal accesses
        access(1'b0, UNMAPPED, 32'h0);
        chk("R11 read err", 32'(host_err), 32'h1);
        chk("R11 read zero", host_rdata, 32'h0);
        @(negedge clk);
        chk("R11 err one cycle", 32'(host_err), 32'h0);
        access(1'b1, OUTBOX, 32'h1234);
        chk("R11 wrong direction", 32'(host_err), 32'h1);
        access(1'b1, RUNCTL, 32'h7);
        chk("R8 ignored value no err", 32'(host_err), 32'h0);
        access(1'b0, RUNCTL, 32'h0);
        chk("R8 value kept", host_rdata, 32'h2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule